// File: doc/BRIEF.md
# Banked External Line Interrupt Controller

This block watches a set of external input lines and turns selected transitions on them into interrupt requests and wake events. The lines are grouped into banks of 32. Line n sits in bank n/32 at bit n mod 32. Each bank keeps its own register group: an interrupt enable mask, a wake-event enable mask, a rising-transition select, a falling-transition select, a software trigger and a pending word. A line can be armed for rising transitions, falling transitions or both. A selected transition sets a sticky pending bit. The pending bit stays set until software writes a 1 to that bit position.

Every input passes through a two-stage synchronizer. A transition is found by comparing the synchronized value with its value one cycle earlier. Each bank drives one interrupt output, which is high while any pending bit in that bank has its interrupt enable bit set. Each line drives a one-cycle event pulse when a selected transition occurs and its wake-event enable bit is set. A parameter sets the number of banks, and a per-line mask parameter sets which lines are built. Software finds the built lines by writing all ones to a select register and reading the value back.

Access goes through one simple request port. A request is a single cycle with a write flag, a byte address and write data. Read data appears on the next cycle and holds until the next read.

Top module: `exti_ctrl`

## Requirements
- R1: After reset, every register reads 0, every interrupt output is low, every event output is low and the read data is 0.
- R2: Bank k's registers start at byte address k*0x400. Within a bank, the word offsets are: 0x00 interrupt enable, 0x04 wake enable, 0x08 rising select, 0x0C falling select, 0x10 software trigger, 0x14 pending. Read data appears one cycle after the read request. Line n maps to bank n/32, bit n mod 32.
- R3: A rising transition on a line whose rising select bit is 1 sets that line's pending bit. The bit is set at the third rising clock edge after the input changes (two synchronizer stages plus the pending register).
- R4: A falling transition sets the pending bit when the falling select bit is 1. When both select bits are 1, either transition sets it.
- R5: A transition whose direction is not selected leaves the pending bit unchanged.
- R6: Writing 1 to a bit of the pending register clears that bit. Writing 0 leaves it unchanged. Pending bits otherwise stay set.
- R7: Writing 1 to a bit of the software trigger register sets the matching pending bit, whatever that line's select bits are. The software trigger register reads 0.
- R8: A bank's interrupt output is high exactly when some pending bit in that bank has its interrupt enable bit set. An enable bit of 0 blocks that line, and one bank's state does not affect another bank's output.
- R9: A line's event output pulses high for one cycle, in the same cycle its pending bit becomes set, when a selected transition occurs and its wake enable bit is 1. The interrupt enable has no effect on the event output.
- R10: Bits of lines that are not built read 0 in every register. Those lines never become pending, not even through the software trigger.
- R11: If a selected transition and a write-1 clear hit the same pending bit in the same cycle, the bit stays set.
- R12: Reads of unused offsets within a bank return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Register access request, one cycle |
| we | input | 1 | 1 for write, 0 for read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| lines | input | NUM_BANKS*32 | External input lines |
| irq | output | NUM_BANKS | Per-bank interrupt request |
| evt | output | NUM_BANKS*32 | Per-line wake event pulse |

## Verification
The bench lands a write-1 clear on the same edge that a rising transition reaches the pending register. A design that let the clear win would lose that event. It drives transitions in the unselected direction and on lines armed for both directions, to catch a design that mixes up the two selects. It writes zeros to the pending word, to catch a design that copies the write data instead of clearing bits. It writes all ones to the select and software trigger registers of a partly built bank, which exposes unbuilt bits that can be stored or set pending. It also checks that an event pulse lasts exactly one cycle and ignores the interrupt enable, and that a write to an unused offset does not alias onto a real register.

// File: rtl/exti_pkg.sv
package exti_pkg;
    localparam int unsigned LINES_PER_BANK = 32;
    localparam int unsigned BANK_SPAN_BITS = 10;   // 0x400 bytes per bank
    localparam int unsigned REG_COUNT      = 6;

    typedef enum logic [2:0] {
        REG_IMASK  = 3'd0,
        REG_EMASK  = 3'd1,
        REG_RISE   = 3'd2,
        REG_FALL   = 3'd3,
        REG_SWTRIG = 3'd4,
        REG_PEND   = 3'd5
    } reg_sel_e;

    typedef logic [LINES_PER_BANK-1:0] bank_word_t;
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] stage1, stage2, prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
            prev   <= '0;
        end else begin
            stage1 <= din;
            stage2 <= stage1;
            prev   <= stage2;
        end
    end

    always_comb begin
        rise = stage2 & ~prev;
        fall = ~stage2 & prev;
    end
endmodule

// File: rtl/exti_bank.sv
module exti_bank
    import exti_pkg::*;
#(
    parameter bank_word_t BUILT = '1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  reg_sel_e   sel,
    input  bank_word_t wdata,
    input  bank_word_t rise,
    input  bank_word_t fall,
    output bank_word_t rd_word,
    output logic       irq,
    output bank_word_t evt
);
    bank_word_t imask, emask, rise_sel, fall_sel, pend, evt_q;
    bank_word_t clr_v, sw_v, hit, set_v;

    always_comb begin
        clr_v = (wr_en && sel == REG_PEND)   ? wdata : '0;
        sw_v  = (wr_en && sel == REG_SWTRIG) ? wdata : '0;
        hit   = (rise & rise_sel) | (fall & fall_sel);
        set_v = (hit | sw_v) & BUILT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imask    <= '0;
            emask    <= '0;
            rise_sel <= '0;
            fall_sel <= '0;
            pend     <= '0;
            evt_q    <= '0;
        end else begin
            if (wr_en) begin
                unique case (sel)
                    REG_IMASK:  imask    <= wdata & BUILT;
                    REG_EMASK:  emask    <= wdata & BUILT;
                    REG_RISE:   rise_sel <= wdata & BUILT;
                    REG_FALL:   fall_sel <= wdata & BUILT;
                    REG_SWTRIG: ;
                    REG_PEND:   ;
                    default:    ;
                endcase
            end
            pend  <= ((pend & ~clr_v) | set_v) & BUILT;
            evt_q <= hit & emask;
        end
    end

    always_comb begin
        unique case (sel)
            REG_IMASK: rd_word = imask;
            REG_EMASK: rd_word = emask;
            REG_RISE:  rd_word = rise_sel;
            REG_FALL:  rd_word = fall_sel;
            REG_PEND:  rd_word = pend;
            default:   rd_word = '0;
        endcase
    end

    assign irq = |(pend & imask);
    assign evt = evt_q;

    // R6: a cleared bit with no concurrent set is gone next cycle
    assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(clr_v & ~set_v)) == '0));

    // R6: pending bits are sticky unless cleared
    assert_sticky_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend) & ~$past(clr_v)) & ~pend) == '0));

    // R11: a set always lands, even against a clear
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
    import exti_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter logic [NUM_BANKS*32-1:0] BUILT_MASK = {32'h0000_007F, 32'hFFFF_FFFF},
    localparam int unsigned BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned ADDR_W    = BANK_BITS + BANK_SPAN_BITS,
    localparam int unsigned N_LINES   = NUM_BANKS * LINES_PER_BANK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [N_LINES-1:0]   lines,
    output logic [NUM_BANKS-1:0] irq,
    output logic [N_LINES-1:0]   evt
);
    logic [BANK_BITS-1:0]      bank_idx;
    logic [BANK_SPAN_BITS-1:0] off;
    logic                      off_ok, bank_ok, hit_ok;
    reg_sel_e                  sel;
    bank_word_t                rd_word [NUM_BANKS];

    always_comb begin
        bank_idx = addr[ADDR_W-1:BANK_SPAN_BITS];
        off      = addr[BANK_SPAN_BITS-1:0];
        off_ok   = (off[BANK_SPAN_BITS-1:5] == '0) && (off[1:0] == 2'b00) &&
                   (off[4:2] < 3'(REG_COUNT));
        bank_ok  = (32'(bank_idx) < NUM_BANKS);
        hit_ok   = off_ok && bank_ok;
        sel      = reg_sel_e'(off[4:2]);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_word_t rise_w, fall_w;

        exti_sync #(.WIDTH(LINES_PER_BANK)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (lines[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .rise (rise_w),
            .fall (fall_w)
        );

        exti_bank #(.BUILT(BUILT_MASK[b*LINES_PER_BANK +: LINES_PER_BANK])) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (req && we && hit_ok && (32'(bank_idx) == b)),
            .sel    (sel),
            .wdata  (wdata),
            .rise   (rise_w),
            .fall   (fall_w),
            .rd_word(rd_word[b]),
            .irq    (irq[b]),
            .evt    (evt[b*LINES_PER_BANK +: LINES_PER_BANK])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (req && !we) begin
            rdata <= hit_ok ? rd_word[bank_idx] : '0;
        end
    end

    // R12: an access outside the register group reads back zero
    assert_unused_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !hit_ok) |=> (rdata == '0));
endmodule

// File: tb/tb_exti_ctrl.sv
module tb_exti_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int AW = 11;
    localparam int OFF_IM = 'h00, OFF_EM = 'h04, OFF_RS = 'h08,
                   OFF_FS = 'h0C, OFF_SW = 'h10, OFF_PD = 'h14;

    logic clk = 0, rst_n = 0, req = 0, we = 0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NB*32-1:0] lines = '0;
    logic [NB-1:0] irq;
    logic [NB*32-1:0] evt;

    int total = 0, bad = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    exti_ctrl #(.NUM_BANKS(NB), .BUILT_MASK({32'h0000_007F, 32'hFFFF_FFFF})) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lines(lines), .irq(irq), .evt(evt));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [AW-1:0] A(input int bank, input int off);
        return AW'(bank * 'h400 + off);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        req = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        req = 0; we = 0;
    endtask

    // driver: pushes the expected word, monitor compares the response
    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req = 1; we = 0; addr = a;
        @(negedge clk);
        req = 0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial forever begin
        @(posedge clk);
        if (req && !we) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard actual=%h expected=none", rdata);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(2);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 evt", evt[31:0] | evt[63:32], 0);
        chk("R1 rdata", rdata, 0);
        rd(A(0, OFF_PD), 0, "R1 pend0");
        rd(A(0, OFF_IM), 0, "R1 imask0");
        // R10 discover built lines
        wr(A(1, OFF_RS), 32'hFFFF_FFFF);
        rd(A(1, OFF_RS), 32'h7F, "R10 built probe");
        wr(A(1, OFF_RS), 0);
        // configure bank 0
        wr(A(0, OFF_RS), 32'h5);
        wr(A(0, OFF_FS), 32'h6);
        wr(A(0, OFF_EM), 32'h1);
        rd(A(0, OFF_FS), 32'h6, "R2 fall select readback");
        // R3 rising on line 0
        lines[0] = 1;
        step(3);
        chk("R9 evt pulse", 32'(evt[0]), 1);
        chk("R8 masked irq", 32'(irq[0]), 0);
        step(1);
        chk("R9 evt one cycle", 32'(evt[0]), 0);
        rd(A(0, OFF_PD), 32'h1, "R3 rising sets");
        // R5 / R4 line 1 (fall only)
        lines[1] = 1; step(3);
        rd(A(0, OFF_PD), 32'h1, "R5 unselected rise");
        lines[1] = 0; step(3);
        rd(A(0, OFF_PD), 32'h3, "R4 falling sets");
        // R4 both on line 2
        lines[2] = 1; step(3);
        chk("R9 evt needs wake enable", 32'(evt[2]), 0);
        rd(A(0, OFF_PD), 32'h7, "R4 both rising");
        wr(A(0, OFF_PD), 32'h4);
        rd(A(0, OFF_PD), 32'h3, "R6 clear bit2");
        lines[2] = 0; step(3);
        rd(A(0, OFF_PD), 32'h7, "R4 both falling");
        // R5 line 3 unselected
        lines[3] = 1; step(3);
        lines[3] = 0; step(3);
        rd(A(0, OFF_PD), 32'h7, "R5 no select");
        // R6
        wr(A(0, OFF_PD), 32'h0);
        rd(A(0, OFF_PD), 32'h7, "R6 write zero");
        wr(A(0, OFF_PD), 32'h1);
        rd(A(0, OFF_PD), 32'h6, "R6 write one");
        // R8
        wr(A(0, OFF_IM), 32'h2);
        chk("R8 irq0 enabled", 32'(irq[0]), 1);
        chk("R8 irq1 quiet", 32'(irq[1]), 0);
        wr(A(0, OFF_PD), 32'h2);
        chk("R8 irq0 after clear", 32'(irq[0]), 0);
        // R7
        wr(A(0, OFF_SW), 32'h8000_0008);
        rd(A(0, OFF_PD), 32'h8000_000C, "R7 sw trigger");
        rd(A(0, OFF_SW), 32'h0, "R7 sw reads zero");
        // R10
        wr(A(1, OFF_SW), 32'hFFFF_FFFF);
        rd(A(1, OFF_PD), 32'h7F, "R10 sw on unbuilt");
        wr(A(1, OFF_PD), 32'hFFFF_FFFF);
        rd(A(1, OFF_PD), 32'h0, "R6 bank1 clear");
        // R2 line mapping: line 32 is bank 1 bit 0
        wr(A(1, OFF_RS), 32'h1);
        lines[32] = 1; step(3);
        rd(A(1, OFF_PD), 32'h1, "R2 line32 bank1");
        rd(A(0, OFF_PD), 32'h8000_000C, "R2 bank0 untouched");
        // R11 transition and clear on the same edge
        wr(A(0, OFF_PD), 32'hFFFF_FFFF);
        lines[0] = 0; step(3);
        rd(A(0, OFF_PD), 32'h0, "R11 precondition");
        lines[0] = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr(A(0, OFF_PD), 32'h1);
        rd(A(0, OFF_PD), 32'h1, "R11 set beats clear");
        // R12 unused offsets
        rd(A(0, 'h18), 32'h0, "R12 unused read");
        wr(A(0, 'h3FC), 32'hFFFF_FFFF);
        rd(A(0, 'h3FC), 32'h0, "R12 unused after write");
        rd(A(0, OFF_IM), 32'h2, "R12 no alias");
        step(2);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard actual=%0d expected=0 leftover", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule